// File: doc/BRIEF.md
# Time-of-Day Serial Display Refresher

This block keeps the time of day as six BCD digits (hours, minutes and seconds, two digits each). It pushes the current time out over a two-wire link to a chain of cascaded serial-in, parallel-out shift registers that feed six numeric display tubes. Each pulse on the one-second tick input advances the time by one second. The same pulse also triggers one 24-bit transfer. The link carries only a data line and a shift clock. It has no select, latch or framing signal, so the word most recently shifted in stays on the register outputs until the next transfer starts.

Internally a small controller packs the updated time into a word, raises a start request to a bit shifter, and waits for the shifter to report completion. It then releases the request. The shifter runs its clock at half the system clock rate, idles it low, and sends the most significant bit first. A tick that arrives during a transfer is held and served once the transfer ends. There is no streaming interface: the tick, the busy flag and the two link pins are plain control and status signals, and the link has no back-pressure.

Top module: `tod_serial_display`

## Requirements
- R1: A synchronous reset drives the shift clock low, serial data low and busy low, and sets the time to 00:00:00, so the first tick after reset produces the word for 00:00:01.
- R2: Seconds and minutes count 00 to 59 and hours count 00 to 23. Every carry ripples correctly, and a tick at 23:59:59 gives 00:00:00.
- R3: The transferred word holds six 4-bit BCD digits. From bit 23 down to bit 0 they are: hours tens (23:20), hours units (19:16), minutes tens (15:12), minutes units (11:8), seconds tens (7:4), seconds units (3:0). The word reflects the time after the tick has been applied.
- R4: Each transfer produces exactly 24 rising shift-clock edges and presents bit 23 first, then the lower bits in descending order.
- R5: The shift clock is low whenever busy is low. During a transfer it is high for exactly one system clock cycle and then low for at least one.
- R6: Serial data never changes on the system clock edge at which the shift clock rises, so it is stable at every rising shift-clock edge.
- R7: If a tick is sampled at clock edge t, busy is high after edge t, the first shift-clock rise happens at edge t+3, the final shift-clock fall happens at edge t+50, and busy falls at edge t+51.
- R8: A tick sampled while busy is high is remembered, and after the current transfer exactly one more transfer follows. Several ticks during one transfer all advance the time but produce only that one extra transfer, which carries the latest time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse once per second; advances time and requests a transfer |
| ser_data | output | 1 | Serial data to the shift-register chain, MSB first |
| ser_clk | output | 1 | Shift clock, idles low, half the system clock rate while active |
| busy | output | 1 | High from the cycle after the tick until the transfer completes |

## Verification
The bench builds the block with its default configuration: a 24-bit word of six 4-bit digits and a shift clock at half the system rate. Ticks can be applied on consecutive cycles, and the held-tick mechanism folds them into a single follow-up transfer. Because of this, the bench can advance through a full day and beyond in about 150,000 cycles. Along the way it reads decoded frames at every digit carry, at the midday and midnight boundaries, and at a stride of 613 seconds that lands on scattered values of all six digits. Every expected word is computed from the total tick count by integer division.

// File: rtl/tod_disp_pkg.sv
package tod_disp_pkg;
  localparam int DIGIT_W  = 4;
  localparam int N_DIGITS = 6;
  localparam int WORD_W   = DIGIT_W * N_DIGITS;

  // digit limits for the time-of-day counter
  localparam int UNIT_LAST   = 9;
  localparam int SIXTY_TENS  = 5;
  localparam int HOUR_T_LAST = 2;
  localparam int HOUR_U_DAY  = 3;

  typedef logic [DIGIT_W-1:0] digit_t;

  // field order is the wire order: hours tens leaves first
  typedef struct packed {
    digit_t hr_t;
    digit_t hr_u;
    digit_t mn_t;
    digit_t mn_u;
    digit_t sc_t;
    digit_t sc_u;
  } tod_t;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_PACK = 2'd1,
    CTL_SEND = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_disp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output tod_t now
);
  tod_t t_q;
  logic c_su, c_st, c_mu, c_mt, day_end;

  always_comb begin
    c_su    = (t_q.sc_u == digit_t'(UNIT_LAST));
    c_st    = c_su && (t_q.sc_t == digit_t'(SIXTY_TENS));
    c_mu    = c_st && (t_q.mn_u == digit_t'(UNIT_LAST));
    c_mt    = c_mu && (t_q.mn_t == digit_t'(SIXTY_TENS));
    day_end = c_mt && (t_q.hr_t == digit_t'(HOUR_T_LAST))
                   && (t_q.hr_u == digit_t'(HOUR_U_DAY));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= '0;
    end else if (tick) begin
      t_q.sc_u <= c_su ? '0 : t_q.sc_u + 1'b1;
      if (c_su) t_q.sc_t <= c_st ? '0 : t_q.sc_t + 1'b1;
      if (c_st) t_q.mn_u <= c_mu ? '0 : t_q.mn_u + 1'b1;
      if (c_mu) t_q.mn_t <= c_mt ? '0 : t_q.mn_t + 1'b1;
      if (day_end) begin
        t_q.hr_t <= '0;
        t_q.hr_u <= '0;
      end else if (c_mt) begin
        if (t_q.hr_u == digit_t'(UNIT_LAST)) begin
          t_q.hr_u <= '0;
          t_q.hr_t <= t_q.hr_t + 1'b1;
        end else begin
          t_q.hr_u <= t_q.hr_u + 1'b1;
        end
      end
    end
  end

  assign now = t_q;
endmodule

// File: rtl/tod_update_ctl.sv
module tod_update_ctl
  import tod_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  tod_t              now,
  input  logic              shift_done,
  output logic [WORD_W-1:0] word,
  output logic              start,
  output logic              busy,
  output logic              pend
);
  ctl_state_e st_q;
  logic       pend_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CTL_IDLE;
      pend_q <= 1'b0;
      word_q <= '0;
    end else begin
      case (st_q)
        CTL_IDLE: begin
          if (tick || pend_q) st_q <= CTL_PACK;
          pend_q <= 1'b0;
        end
        CTL_PACK: begin
          word_q <= now;
          pend_q <= pend_q | tick;
          st_q   <= CTL_SEND;
        end
        CTL_SEND: begin
          pend_q <= pend_q | tick;
          if (shift_done) st_q <= CTL_IDLE;
        end
        default: st_q <= CTL_IDLE;
      endcase
    end
  end

  assign word  = word_q;
  assign start = (st_q == CTL_SEND);
  assign busy  = (st_q != CTL_IDLE);
  assign pend  = pend_q;
endmodule

// File: rtl/tod_bit_shifter.sv
module tod_bit_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] par_in,
  output logic         sdo,
  output logic         sck,
  output logic         done
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  logic         active_q, sck_q, done_q;
  logic [W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      sck_q <= 1'b0;
      sh_q  <= par_in;              // parallel load only while idle
      if (!start) done_q <= 1'b0;
      if (start && !done_q) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end else begin
      sck_q <= ~sck_q;
      if (sck_q) begin              // falling shift-clock edge: next bit
        sh_q <= {sh_q[W-2:0], 1'b0};
        if (cnt_q == LAST_BIT) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sdo  = sh_q[W-1];
  assign sck  = sck_q;
  assign done = done_q;
endmodule

// File: rtl/tod_serial_display.sv
module tod_serial_display
  import tod_disp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  output logic ser_data,
  output logic ser_clk,
  output logic busy
);
  tod_t              now_time;
  logic [WORD_W-1:0] disp_word;
  logic              go, fin, pend_q;

  tod_counter u_time (
    .clk  (clk),
    .rst  (rst),
    .tick (sec_tick),
    .now  (now_time)
  );

  tod_update_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .tick       (sec_tick),
    .now        (now_time),
    .shift_done (fin),
    .word       (disp_word),
    .start      (go),
    .busy       (busy),
    .pend       (pend_q)
  );

  tod_bit_shifter #(.W(WORD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (go),
    .par_in (disp_word),
    .sdo    (ser_data),
    .sck    (ser_clk),
    .done   (fin)
  );
endmodule

// File: rtl/tod_disp_chk.sv
module tod_disp_chk
  import tod_disp_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic sec_tick,
  input logic ser_clk,
  input logic ser_data,
  input logic busy,
  input logic pend,
  input tod_t now
);
  // R5
  sck_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> busy);

  // R5
  sck_high_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ser_clk |=> !ser_clk);

  // R6
  data_stable_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_data));

  // R7
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(sec_tick) || $past(pend)));

  // R8
  tick_held_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && sec_tick) |=> pend);

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (now.sc_u <= 4'd9) && (now.sc_t <= 4'd5) && (now.mn_u <= 4'd9) &&
    (now.mn_t <= 4'd5) && (now.hr_t <= 4'd2) &&
    ((now.hr_t == 4'd2) ? (now.hr_u <= 4'd3) : (now.hr_u <= 4'd9)));
endmodule

bind tod_serial_display tod_disp_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sec_tick (sec_tick),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .busy     (busy),
  .pend     (pend_q),
  .now      (now_time)
);

// File: tb/tod_serial_display_bench.sv
module tod_serial_display_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic ser_data, ser_clk, busy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int total = 0;
  bit done_flag = 1'b0;

  // monitor state
  logic        prev_sck = 1'b0, prev_busy = 1'b0, prev_data = 1'b0;
  logic [23:0] cap = '0, last_frame = '0;
  int nbits = 0, last_nbits = 0, frame_cnt = 0;
  int idle_sck_err = 0, width_err = 0, stab_err = 0;

  tod_serial_display u_tod_serial_display (
    .clk      (clk),
    .rst      (rst),
    .sec_tick (sec_tick),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .busy     (busy)
  );

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && !busy) idle_sck_err++;
      if (ser_clk && prev_sck) width_err++;
      if (ser_clk && !prev_sck) begin
        if (ser_data !== prev_data) stab_err++;
        cap = {cap[22:0], ser_data};
        nbits++;
      end
      if (prev_busy && !busy) begin
        last_frame = cap;
        last_nbits = nbits;
        nbits = 0;
        frame_cnt++;
      end
    end
    prev_sck  = ser_clk;
    prev_busy = busy;
    prev_data = ser_data;
  end

  function automatic logic [23:0] exp_word(input int n);
    int s, h, m, sc;
    s  = n % 86400;
    h  = s / 3600;
    m  = (s / 60) % 60;
    sc = s % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(sc / 10), 4'(sc % 10)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    total++;
  endtask

  task automatic burst(input int n);
    if (n > 0) begin
      @(negedge clk) sec_tick = 1'b1;
      repeat (n) @(negedge clk);
      sec_tick = 1'b0;
      total += n;
    end
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!busy) q++; else q = 0;
    end
  endtask

  task automatic step_to(input int target, input string req);
    int f0;
    burst(target - total - 1);
    wait_idle();
    f0 = frame_cnt;
    pulse_tick();
    wait_idle();
    chk(frame_cnt == f0 + 1, req, "one frame per tick", frame_cnt - f0, 1);
    chk(last_nbits == 24, "R4", "shift clock rises", last_nbits, 24);
    chk(last_frame == exp_word(total), req, "frame word",
        int'(last_frame), int'(exp_word(total)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c0, f0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    chk(ser_clk == 1'b0, "R1", "ser_clk after reset", ser_clk, 0);
    chk(ser_data == 1'b0, "R1", "ser_data after reset", ser_data, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    step_to(1, "R1");

    // R7 cycle timing of one transfer
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    total++;
    c0 = cyc;
    chk(busy == 1'b1, "R7", "busy after tick edge", busy, 1);
    while (!ser_clk) @(negedge clk);
    chk(cyc - c0 == 3, "R7", "edges to first rise", cyc - c0, 3);
    while (busy) @(negedge clk);
    chk(cyc - c0 == 51, "R7", "edges to busy low", cyc - c0, 51);
    wait_idle();
    chk(last_frame == exp_word(total), "R3", "timed frame",
        int'(last_frame), int'(exp_word(total)));

    // R8 ticks during a transfer fold into one extra transfer
    f0 = frame_cnt;
    pulse_tick();
    repeat (10) @(negedge clk);
    pulse_tick();
    repeat (5) @(negedge clk);
    pulse_tick();
    wait_idle();
    chk(frame_cnt == f0 + 2, "R8", "frames for three ticks", frame_cnt - f0, 2);
    chk(last_frame == exp_word(total), "R8", "follow-up frame",
        int'(last_frame), int'(exp_word(total)));

    // R2 carries and day wrap
    step_to(59, "R2");
    step_to(60, "R2");
    step_to(61, "R2");
    step_to(599, "R2");
    step_to(600, "R2");
    step_to(3599, "R2");
    step_to(3600, "R2");
    step_to(3601, "R2");
    step_to(35999, "R2");
    step_to(36000, "R2");
    step_to(43199, "R3");
    step_to(43200, "R3");
    step_to(86399, "R2");
    step_to(86400, "R2");
    step_to(86401, "R2");

    // R3 stride sweep through varied digit values
    for (int k = 0; k < 70; k++) step_to(total + 613, "R3");

    chk(idle_sck_err == 0, "R5", "shift clock high while idle", idle_sck_err, 0);
    chk(width_err == 0, "R5", "shift clock high two cycles", width_err, 0);
    chk(stab_err == 0, "R6", "data change at rise", stab_err, 0);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule